// File: doc/BRIEF.md
# Module Call Level Transfer Validator

This block guards every change of privilege level made when a routine calls into another module or returns from one. It holds two small level registers. The current level is the privilege the running task has now. The caller level is the privilege of the routine that made the most recent call. Level 0 is the most privileged; larger numbers mean less privilege. A call or a return is accepted only if it keeps privilege the same or lowers it. This stops a routine from gaining privilege, for example by forging a saved level on its stack before it returns. Both checks compare with the current level.

The block also answers pointer validation requests. The top level bits of an address are compared with the caller level, so a called routine can find out whether its caller could have used that address. At dispatch time the operating system loads both registers through a small write port. A configuration input selects 1, 2 or 3 level bits. Every result is registered and appears on the cycle after its request.

Top module: `lvl_xfer_guard`

## Requirements
- R1: After a synchronous active-high reset, `cur_lvl` and `caller_lvl` are 0, and every result flag (`call_ok`, `call_bad`, `ret_ok`, `ret_bad`, `stack_swap`, `chk_done`, `chk_exc`) is 0.
- R2: `lvl_cfg` gives the number of level bits: 1, 2 or 3, with 0 treated as 1. Each operand level and each written value is masked to its low bits of that width. `cur_lvl` and `caller_lvl` show the stored values masked the same way. The level of an address is its top bits of that width, read as an unsigned number.
- R3: A call request raises `call_ok` on the next cycle when the masked target level is greater than or equal to `cur_lvl`. Otherwise it raises `call_bad` on the next cycle.
- R4: An accepted call copies the old current level into `caller_lvl` and loads the target level into `cur_lvl`. Both values are visible on the next cycle.
- R5: A return request raises `ret_ok` on the next cycle when the masked restored level is greater than or equal to `cur_lvl`, and then loads it into `cur_lvl`. `caller_lvl` is left unchanged. Otherwise it raises `ret_bad` on the next cycle.
- R6: A rejected call or return leaves `cur_lvl` and `caller_lvl` unchanged.
- R7: `stack_swap` pulses on the cycle after an accepted call or return whose new level differs from the old current level. It stays 0 in every other case.
- R8: A validate request raises `chk_done` on the next cycle. In the same cycle `chk_exc` is 1 exactly when the address level is less than the `caller_lvl` held in the request cycle.
- R9: With `wr_en` high, `wr_sel` = 0 writes `cur_lvl` and `wr_sel` = 1 writes `caller_lvl`. The new value is visible on the next cycle. In a cycle with `wr_en` high, call and return requests are ignored: they produce no flag and change no register.
- R10: When a call and a return are requested in the same cycle, only the call is handled. The return produces no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_cfg | input | 2 | Number of level bits (1..3, 0 acts as 1) |
| wr_en | input | 1 | Operating system register write strobe |
| wr_sel | input | 1 | Write target: 0 current level, 1 caller level |
| wr_data | input | 3 | Level value to write |
| call_req | input | 1 | Module call strobe |
| call_lvl | input | 3 | Target level of the call |
| ret_req | input | 1 | Module return strobe |
| ret_lvl | input | 3 | Level restored by the return |
| chk_req | input | 1 | Pointer validation strobe |
| chk_addr | input | ADDR_W | Address to validate |
| call_ok | output | 1 | Call accepted |
| call_bad | output | 1 | Call rejected |
| ret_ok | output | 1 | Return accepted |
| ret_bad | output | 1 | Return rejected |
| stack_swap | output | 1 | Stack change request |
| chk_done | output | 1 | Validation result valid |
| chk_exc | output | 1 | Validation exception |
| cur_lvl | output | 3 | Current level |
| caller_lvl | output | 3 | Caller level |

## Verification
For every width, the bench sweeps all pairs of current level and requested level for calls, and all pairs of current level and restored level for returns. This covers the equal-level case. A design that used a strict comparison would reject those equal-level requests, and one that compared the wrong way round would let a routine gain privilege. Pointer checks are swept over all caller levels and all address levels, so taking the wrong address bits or using the wrong shift for a narrow width shows up as wrong exceptions.

Three collisions are tested directly: a write together with a call, a call together with a return, and a configuration value of 0. The bench also checks that a rejected call does not save the caller level, and that a return does not overwrite it.

// File: rtl/lvl_xfer_pkg.sv
package lvl_xfer_pkg;

    localparam int LVL_W = 3;
    localparam int CFG_W = $clog2(LVL_W + 1);

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [CFG_W-1:0] cfg_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_CALL = 2'd1,
        OP_RET  = 2'd2
    } op_e;

    typedef struct packed {
        op_e  op;
        logic legal;
        logic swap;
        lvl_t next_cur;
        lvl_t next_caller;
    } xfer_res_t;

    // number of active level bits, a zero setting acts as one bit
    function automatic cfg_t eff_bits(cfg_t cfg);
        cfg_t n;
        if (cfg == '0)
            n = cfg_t'(1);
        else if (cfg > cfg_t'(LVL_W))
            n = cfg_t'(LVL_W);
        else
            n = cfg;
        return n;
    endfunction

    function automatic lvl_t lvl_mask(lvl_t v, cfg_t cfg);
        localparam logic [LVL_W:0] ONE = 1;
        logic [LVL_W:0] ones;
        ones = (ONE << eff_bits(cfg)) - ONE;
        return v & ones[LVL_W-1:0];
    endfunction

endpackage

// File: rtl/lvl_operand_mask.sv
module lvl_operand_mask
    import lvl_xfer_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  cfg_t              cfg,
    input  lvl_t              call_raw,
    input  lvl_t              ret_raw,
    input  lvl_t              wr_raw,
    input  logic [ADDR_W-1:0] addr,
    output lvl_t              call_m,
    output lvl_t              ret_m,
    output lvl_t              wr_m,
    output lvl_t              addr_lvl
);
    lvl_t top_bits;
    cfg_t shamt;

    always_comb begin
        call_m   = lvl_mask(call_raw, cfg);
        ret_m    = lvl_mask(ret_raw, cfg);
        wr_m     = lvl_mask(wr_raw, cfg);
        top_bits = addr[ADDR_W-1 -: LVL_W];
        shamt    = cfg_t'(LVL_W) - eff_bits(cfg);
        addr_lvl = top_bits >> shamt;
    end
endmodule

// File: rtl/lvl_xfer_judge.sv
module lvl_xfer_judge
    import lvl_xfer_pkg::*;
(
    input  logic      wr_en,
    input  logic      call_req,
    input  logic      ret_req,
    input  lvl_t      call_m,
    input  lvl_t      ret_m,
    input  lvl_t      cur,
    input  lvl_t      caller,
    output xfer_res_t res
);
    always_comb begin
        res             = '0;
        res.op          = OP_NONE;
        res.next_cur    = cur;
        res.next_caller = caller;
        if (!wr_en) begin
            if (call_req)
                res.op = OP_CALL;
            else if (ret_req)
                res.op = OP_RET;
        end
        case (res.op)
            OP_CALL: begin
                if (call_m >= cur) begin
                    res.legal       = 1'b1;
                    res.swap        = (call_m != cur);
                    res.next_caller = cur;
                    res.next_cur    = call_m;
                end
            end
            OP_RET: begin
                if (ret_m >= cur) begin
                    res.legal    = 1'b1;
                    res.swap     = (ret_m != cur);
                    res.next_cur = ret_m;
                end
            end
            default: begin
                res.legal = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lvl_state_regs.sv
module lvl_state_regs
    import lvl_xfer_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic      wr_sel,
    input  lvl_t      wr_m,
    input  xfer_res_t res,
    output lvl_t      cur_q,
    output lvl_t      caller_q,
    output logic      call_ok,
    output logic      call_bad,
    output logic      ret_ok,
    output logic      ret_bad,
    output logic      stack_swap
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q      <= '0;
            caller_q   <= '0;
            call_ok    <= 1'b0;
            call_bad   <= 1'b0;
            ret_ok     <= 1'b0;
            ret_bad    <= 1'b0;
            stack_swap <= 1'b0;
        end else begin
            cur_q      <= (wr_en && !wr_sel) ? wr_m : res.next_cur;
            caller_q   <= (wr_en &&  wr_sel) ? wr_m : res.next_caller;
            call_ok    <= (res.op == OP_CALL) &&  res.legal;
            call_bad   <= (res.op == OP_CALL) && !res.legal;
            ret_ok     <= (res.op == OP_RET)  &&  res.legal;
            ret_bad    <= (res.op == OP_RET)  && !res.legal;
            stack_swap <= res.swap;
        end
    end
endmodule

// File: rtl/lvl_ptr_probe.sv
module lvl_ptr_probe
    import lvl_xfer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic chk_req,
    input  lvl_t addr_lvl,
    input  lvl_t caller,
    output logic chk_done,
    output logic chk_exc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_done <= 1'b0;
            chk_exc  <= 1'b0;
        end else begin
            chk_done <= chk_req;
            chk_exc  <= chk_req && (addr_lvl < caller);
        end
    end
endmodule

// File: rtl/lvl_xfer_guard.sv
module lvl_xfer_guard
    import lvl_xfer_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        lvl_cfg,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [2:0]        wr_data,
    input  logic              call_req,
    input  logic [2:0]        call_lvl,
    input  logic              ret_req,
    input  logic [2:0]        ret_lvl,
    input  logic              chk_req,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              call_ok,
    output logic              call_bad,
    output logic              ret_ok,
    output logic              ret_bad,
    output logic              stack_swap,
    output logic              chk_done,
    output logic              chk_exc,
    output logic [2:0]        cur_lvl,
    output logic [2:0]        caller_lvl
);
    lvl_t      call_m, ret_m, wr_m, addr_lvl;
    lvl_t      cur_q, caller_q, cur_v, caller_v;
    xfer_res_t res;

    lvl_operand_mask #(.ADDR_W(ADDR_W)) u_mask (
        .cfg      (lvl_cfg),
        .call_raw (call_lvl),
        .ret_raw  (ret_lvl),
        .wr_raw   (wr_data),
        .addr     (chk_addr),
        .call_m   (call_m),
        .ret_m    (ret_m),
        .wr_m     (wr_m),
        .addr_lvl (addr_lvl)
    );

    assign cur_v    = lvl_mask(cur_q, lvl_cfg);
    assign caller_v = lvl_mask(caller_q, lvl_cfg);

    lvl_xfer_judge u_judge (
        .wr_en    (wr_en),
        .call_req (call_req),
        .ret_req  (ret_req),
        .call_m   (call_m),
        .ret_m    (ret_m),
        .cur      (cur_v),
        .caller   (caller_v),
        .res      (res)
    );

    lvl_state_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_m       (wr_m),
        .res        (res),
        .cur_q      (cur_q),
        .caller_q   (caller_q),
        .call_ok    (call_ok),
        .call_bad   (call_bad),
        .ret_ok     (ret_ok),
        .ret_bad    (ret_bad),
        .stack_swap (stack_swap)
    );

    lvl_ptr_probe u_probe (
        .clk      (clk),
        .rst      (rst),
        .chk_req  (chk_req),
        .addr_lvl (addr_lvl),
        .caller   (caller_v),
        .chk_done (chk_done),
        .chk_exc  (chk_exc)
    );

    assign cur_lvl    = cur_v;
    assign caller_lvl = caller_v;
endmodule

// File: rtl/lvl_xfer_guard_chk.sv
module lvl_xfer_guard_chk
    import lvl_xfer_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        lvl_cfg,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [2:0]        wr_data,
    input logic              call_req,
    input logic [2:0]        call_lvl,
    input logic              ret_req,
    input logic [2:0]        ret_lvl,
    input logic              chk_req,
    input logic [ADDR_W-1:0] chk_addr,
    input logic              call_ok,
    input logic              call_bad,
    input logic              ret_ok,
    input logic              ret_bad,
    input logic              stack_swap,
    input logic              chk_done,
    input logic              chk_exc,
    input logic [2:0]        cur_lvl,
    input logic [2:0]        caller_lvl
);
    a_r3_call_accepted: assert property (@(posedge clk) disable iff (rst)
        (call_req && !wr_en && (lvl_mask(call_lvl, lvl_cfg) >= cur_lvl)) |=> call_ok);

    a_r3_call_rejected: assert property (@(posedge clk) disable iff (rst)
        (call_req && !wr_en && (lvl_mask(call_lvl, lvl_cfg) < cur_lvl)) |=> call_bad);

    a_r4_caller_saved: assert property (@(posedge clk) disable iff (rst)
        (call_req && !wr_en && (lvl_mask(call_lvl, lvl_cfg) >= cur_lvl))
        |=> (($past(lvl_cfg) != lvl_cfg) || (caller_lvl == $past(cur_lvl))));

    a_r5_ret_rejected: assert property (@(posedge clk) disable iff (rst)
        (ret_req && !call_req && !wr_en && (lvl_mask(ret_lvl, lvl_cfg) < cur_lvl)) |=> ret_bad);

    a_r6_reject_holds: assert property (@(posedge clk) disable iff (rst)
        ((call_bad || ret_bad) && $stable(lvl_cfg)) |-> ($stable(cur_lvl) && $stable(caller_lvl)));

    a_r7_swap_on_accept: assert property (@(posedge clk) disable iff (rst)
        stack_swap |-> (call_ok || ret_ok));

    a_r8_exc_with_done: assert property (@(posedge clk) disable iff (rst)
        chk_exc |-> chk_done);

    a_r9_write_blocks: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !(call_ok || call_bad || ret_ok || ret_bad));

    a_r10_single_result: assert property (@(posedge clk) disable iff (rst)
        $onehot0({call_ok, call_bad, ret_ok, ret_bad}));
endmodule

bind lvl_xfer_guard lvl_xfer_guard_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/lvl_xfer_guard_test.sv
`timescale 1ns/1ps
module lvl_xfer_guard_test;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        lvl_cfg = 2'd3;
    logic              wr_en = 1'b0, wr_sel = 1'b0;
    logic [2:0]        wr_data = '0;
    logic              call_req = 1'b0, ret_req = 1'b0, chk_req = 1'b0;
    logic [2:0]        call_lvl = '0, ret_lvl = '0;
    logic [ADDR_W-1:0] chk_addr = '0;
    logic call_ok, call_bad, ret_ok, ret_bad, stack_swap, chk_done, chk_exc;
    logic [2:0] cur_lvl, caller_lvl;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lvl_xfer_guard #(.ADDR_W(ADDR_W)) uut (.*);

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int msk(int v, int nb);
        return v & ((1 << nb) - 1);
    endfunction

    task automatic step();
        @(negedge clk);
        wr_en = 0; call_req = 0; ret_req = 0; chk_req = 0;
    endtask

    task automatic wr(bit sel, int d);
        wr_en = 1; wr_sel = sel; wr_data = 3'(d);
        step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 cur", cur_lvl, 0);
        check("R1 caller", caller_lvl, 0);
        check("R1 flags", {call_ok, call_bad, ret_ok, ret_bad, stack_swap, chk_done, chk_exc}, 0);

        // R3 R4 R6 R7 call sweep
        for (int nb = 1; nb <= 3; nb++) begin
            lvl_cfg = 2'(nb);
            for (int c = 0; c < 8; c++) begin
                for (int t = 0; t < 8; t++) begin
                    int cm, tm, vm;
                    bit ok;
                    cm = msk(c, nb); tm = msk(t, nb); vm = msk(7, nb);
                    ok = (tm >= cm);
                    wr(0, c);
                    wr(1, 7);
                    call_req = 1; call_lvl = 3'(t);
                    step();
                    check("R3 call_ok", call_ok, ok);
                    check("R3 call_bad", call_bad, !ok);
                    check("R4 cur after call", cur_lvl, ok ? tm : cm);
                    check("R4 R6 caller after call", caller_lvl, ok ? cm : vm);
                    check("R7 swap call", stack_swap, ok && (tm != cm));
                end
            end
        end

        // R5 R6 R7 return sweep
        for (int nb = 1; nb <= 3; nb++) begin
            lvl_cfg = 2'(nb);
            for (int c = 0; c < 8; c++) begin
                for (int r = 0; r < 8; r++) begin
                    int cm, rm, vm;
                    bit ok;
                    cm = msk(c, nb); rm = msk(r, nb); vm = msk(2, nb);
                    ok = (rm >= cm);
                    wr(0, c);
                    wr(1, 2);
                    ret_req = 1; ret_lvl = 3'(r);
                    step();
                    check("R5 ret_ok", ret_ok, ok);
                    check("R5 ret_bad", ret_bad, !ok);
                    check("R5 R6 cur after ret", cur_lvl, ok ? rm : cm);
                    check("R5 caller kept", caller_lvl, vm);
                    check("R7 swap ret", stack_swap, ok && (rm != cm));
                end
            end
        end

        // R8 pointer validation sweep
        for (int nb = 1; nb <= 3; nb++) begin
            lvl_cfg = 2'(nb);
            for (int v = 0; v < 8; v++) begin
                wr(1, v);
                for (int a = 0; a < 8; a++) begin
                    int al;
                    al = a >> (3 - nb);
                    chk_req = 1;
                    chk_addr = {3'(a), 29'h0ABC_DEF1};
                    step();
                    check("R8 chk_done", chk_done, 1);
                    check("R8 chk_exc", chk_exc, al < msk(v, nb));
                end
            end
        end
        step();
        check("R8 done drops", chk_done, 0);

        // R2 zero setting acts as one bit
        lvl_cfg = 2'd0;
        wr(0, 3);
        check("R2 cfg0 cur", cur_lvl, 1);
        wr(1, 6);
        check("R2 cfg0 caller", caller_lvl, 0);

        // R9 write beats call in the same cycle
        lvl_cfg = 2'd3;
        wr(1, 4);
        wr_en = 1; wr_sel = 0; wr_data = 3'd2;
        call_req = 1; call_lvl = 3'd5;
        step();
        check("R9 no call flag", {call_ok, call_bad}, 0);
        check("R9 cur written", cur_lvl, 2);
        check("R9 caller untouched", caller_lvl, 4);

        // R10 call and return together: call wins
        ret_req = 1; ret_lvl = 3'd7;
        call_req = 1; call_lvl = 3'd3;
        step();
        check("R10 call_ok", call_ok, 1);
        check("R10 no ret flag", {ret_ok, ret_bad}, 0);
        check("R10 cur", cur_lvl, 3);
        check("R10 caller", caller_lvl, 2);

        // R1 reset again clears state
        rst = 1;
        step();
        rst = 0;
        check("R1 reset cur", cur_lvl, 0);
        check("R1 reset caller", caller_lvl, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule